// File: doc/BRIEF.md
# Pulse Period and High-Time Meter

The meter measures one digital waveform. It reports the length of one cycle and the time the signal spends high in each cycle. A free-running tick counter is sampled into a rise register on qualifying rising edges and into a fall register on qualifying falling edges. Both registers are fed from the same input.

Each qualifying rising edge takes a snapshot of the two registers as a pair. The first snapshot only supplies the reference time. The second snapshot completes the measurement. The arithmetic then corrects for:

- counter wrap,
- a falling edge that lands in the fall register before the snapshot is taken,
- the phase of the edge divider when the run starts while the input is high.

A controller sets the tick divider, the edge divider code and a timeout, then pulses `start`. It waits for `done` and reads `period`, `high` and `err`. If the second snapshot does not arrive in time, the run is abandoned with `err` set. The counter and both capture paths stop whenever a run ends.

Top module: `pwm_meter`

## Requirements
- R1: The input passes through a two-flop synchronizer and an edge detector. For a waveform starting low with code 0, `period` and `high` equal the cycle length and the high time, counted in ticks.
- R2: The counter advances once every `tick_div`+1 clock cycles while busy, and holds while idle. Results are in counter ticks, so a cycle of P clocks reads P/(`tick_div`+1).
- R3: Differences are taken modulo 2^CW. A period or high time whose end capture has wrapped past the counter's top value is still reported correctly.
- R4: The first qualifying rising edge only supplies the reference time. After the second one, `done` pulses for one cycle with results valid, `err` is 0 and `busy` is already low.
- R5: The fall register is read two clock cycles after the closing rising edge. If a falling edge lands in between, the raw high time exceeds the raw period, and the period is subtracted from it. A 1-clock high pulse at `tick_div`=0 then reads as 1.
- R6: `edge_sel` codes 0, 1, 2 and 3 make both paths capture on every 1st, 2nd, 4th or 8th edge. `period` reports the captured span shifted right by the code, which is one cycle.
- R7: With a nonzero code, a raw high time of at least (raw span >> code) means the run began in a high phase. `high` is then (span >> code) − (span − raw high), which is the true high time.
- R8: When built with HAS_FALL=0, `high` is always 0.
- R9: If the run has not completed after `tmo_lim` (≥1) busy cycles, `done` pulses with `err`=1, and `period` and `high` keep their previous values.
- R10: After reset, `busy`, `done`, `err`, `period` and `high` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin | input | 1 | Measured waveform (asynchronous) |
| start | input | 1 | Begin a run; ignored while busy |
| tick_div | input | PW | Counter advances every tick_div+1 clocks |
| edge_sel | input | 2 | Edge divider code, latched at start |
| tmo_lim | input | TW | Timeout in clock cycles |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Last run timed out |
| period | output | CW | Cycle length in ticks |
| high | output | CW | High time in ticks |

## Verification
The bench builds the meter with CW=8, so the counter wraps every 256 ticks. This puts a wrapped end capture within reach of a short lead-in, and keeps an 8-cycle span of a 30-tick waveform inside range.

A second instance built with HAS_FALL=0 shares every input, so the single-path result is compared on each run. Runs started high and started low at codes 1 to 3 reach the phase correction, and a 1-clock pulse at `tick_div`=0 reaches the overrun correction.

// File: rtl/pwm_meter.sv
module pwm_meter #(
  parameter int CW = 16,
  parameter int PW = 8,
  parameter int TW = 24,
  parameter int HAS_FALL = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin,
  input  logic          start,
  input  logic [PW-1:0] tick_div,
  input  logic [1:0]    edge_sel,
  input  logic [TW-1:0] tmo_lim,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [CW-1:0] period,
  output logic [CW-1:0] high
);

  logic          s1, s2, s3;
  logic [1:0]    code;
  logic [2:0]    rdiv, fdiv, emask;
  logic [CW-1:0] cnt, rcap, fcap, t0;
  logic [PW-1:0] pcnt;
  logic [TW-1:0] tmo;
  logic          have_t0;
  logic [1:0]    pend;

  wire rise   = s2 & ~s3;
  wire fall   = ~s2 & s3;
  assign emask = 3'b111 >> (2'd3 - code);
  wire rise_q = busy & rise & (rdiv == emask);
  wire fall_q = busy & fall & (fdiv == emask) & (HAS_FALL != 0);
  wire fin    = pend[1] & have_t0;

  logic [CW-1:0] praw, hraw, h1, pshift, h2;
  assign praw   = rcap - t0;
  assign hraw   = fcap - t0;
  assign h1     = (hraw > praw) ? hraw - praw : hraw;
  assign pshift = praw >> code;
  assign h2     = (code != 2'd0 && h1 >= pshift) ? pshift - (praw - h1) : h1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s3, s2, s1} <= '0;
    end else begin
      {s3, s2, s1} <= {s2, s1, pin};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; err <= 1'b0;
      period <= '0; high <= '0;
      code <= '0; rdiv <= '0; fdiv <= '0;
      cnt <= '0; pcnt <= '0; tmo <= '0;
      rcap <= '0; fcap <= '0; t0 <= '0;
      have_t0 <= 1'b0; pend <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; err <= 1'b0;
          cnt <= '0; pcnt <= '0; tmo <= '0;
          rdiv <= '0; fdiv <= '0;
          have_t0 <= 1'b0; pend <= '0;
          code <= edge_sel;
        end
      end else begin
        tmo <= tmo + 1'b1;
        if (pcnt == tick_div) begin
          pcnt <= '0;
          cnt  <= cnt + 1'b1;
        end else begin
          pcnt <= pcnt + 1'b1;
        end
        if (rise) rdiv <= (rdiv == emask) ? 3'd0 : rdiv + 3'd1;
        if (fall) fdiv <= (fdiv == emask) ? 3'd0 : fdiv + 3'd1;
        if (rise_q) rcap <= cnt;
        if (fall_q) fcap <= cnt;
        pend <= {pend[0], rise_q};
        if (pend[1] && !have_t0) begin
          t0      <= rcap;
          have_t0 <= 1'b1;
        end
        if (fin) begin
          period <= pshift;
          high   <= (HAS_FALL != 0) ? h2 : '0;
          done   <= 1'b1;
          busy   <= 1'b0;
        end else if ((tmo + 1'b1) == tmo_lim) begin
          done <= 1'b1;
          err  <= 1'b1;
          busy <= 1'b0;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R4
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> $stable(cnt)); // R2
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> ($stable(period) && $stable(high))); // R9
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) $rose(err) |-> done); // R9
  AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (busy && tmo_lim != '0) |-> (tmo < tmo_lim)); // R9

endmodule

// File: tb/sim_pwm_meter.sv
module sim_pwm_meter;
  localparam int CW = 8;
  localparam int PW = 4;
  localparam int TW = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, pin, start;
  logic [PW-1:0] tick_div;
  logic [1:0] edge_sel;
  logic [TW-1:0] tmo_lim;
  logic busy, done, err, busy1, done1, err1;
  logic [CW-1:0] period, high, period1, high1;

  pwm_meter #(.CW(CW), .PW(PW), .TW(TW), .HAS_FALL(1)) u0 (
    .clk(clk), .rst_n(rst_n), .pin(pin), .start(start), .tick_div(tick_div),
    .edge_sel(edge_sel), .tmo_lim(tmo_lim), .busy(busy), .done(done), .err(err),
    .period(period), .high(high));

  pwm_meter #(.CW(CW), .PW(PW), .TW(TW), .HAS_FALL(0)) u1 (
    .clk(clk), .rst_n(rst_n), .pin(pin), .start(start), .tick_div(tick_div),
    .edge_sel(edge_sel), .tmo_lim(tmo_lim), .busy(busy1), .done(done1), .err(err1),
    .period(period1), .high(high1));

  int checks = 0, fails = 0;
  int qp[$], qh[$], qe[$];
  string qr[$];
  int last_p = 0, last_h = 0;
  bit ended = 0;

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic report();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    int p, h, e;
    string t;
    if (rst_n && done) begin
      if (qp.size() == 0) begin
        chk("R4 unexpected done", 1, 0);
      end else begin
        p = qp.pop_front(); h = qh.pop_front(); e = qe.pop_front(); t = qr.pop_front();
        chk({t, " period"}, int'(period), p);
        chk({t, " high"}, int'(high), h);
        chk({t, " err"}, int'(err), e);
        chk("R4 busy low at done", int'(busy), 0);
        chk("R8 single path high", int'(high1), 0);
      end
    end
  end

  task automatic drain();
    for (int k = 0; k < 2000 && qp.size() != 0; k++) @(negedge clk);
    if (qp.size() != 0) begin
      chk("R4 done missing", 0, 1);
      qp.delete(); qh.delete(); qe.delete(); qr.delete();
    end
  endtask

  task automatic measure(input string tag, input int d, input int c, input int p,
                         input int h, input bit hi, input int pre);
    int n;
    n = 1 << c;
    @(negedge clk);
    tick_div = PW'(d); edge_sel = 2'(c); tmo_lim = TW'(100000); pin = hi;
    repeat (6) @(negedge clk);
    last_p = p / (d + 1); last_h = h / (d + 1);
    qp.push_back(last_p); qh.push_back(last_h); qe.push_back(0); qr.push_back(tag);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (pre) @(negedge clk);
    for (int i = 0; i < 2 * n + 2; i++) begin
      if (hi) begin
        pin = 1'b1; repeat (h) @(negedge clk);
        pin = 1'b0; repeat (p - h) @(negedge clk);
      end else begin
        pin = 1'b0; repeat (p - h) @(negedge clk);
        pin = 1'b1; repeat (h) @(negedge clk);
      end
    end
    drain();
  endtask

  task automatic timeout_run();
    @(negedge clk);
    tick_div = '0; edge_sel = '0; tmo_lim = TW'(60); pin = 1'b0;
    repeat (6) @(negedge clk);
    qp.push_back(last_p); qh.push_back(last_h); qe.push_back(1); qr.push_back("R9 timeout");
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    chk("R9 still busy before limit", int'(busy), 1);
    drain();
  endtask

  initial begin
    rst_n = 1'b0; pin = 1'b0; start = 1'b0; tick_div = '0; edge_sel = '0; tmo_lim = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 busy", int'(busy), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 err", int'(err), 0);
    chk("R10 period", int'(period), 0);
    chk("R10 high", int'(high), 0);
    measure("R1 basic", 0, 0, 40, 10, 1'b0, 0);
    measure("R2 tick divide", 3, 0, 80, 24, 1'b0, 0);
    measure("R3 wrap", 0, 0, 100, 80, 1'b0, 200);
    measure("R5 overrun", 0, 0, 30, 1, 1'b0, 0);
    measure("R6 code1", 0, 1, 40, 15, 1'b0, 0);
    measure("R6 code2 tick", 1, 2, 40, 12, 1'b0, 0);
    measure("R7 code3 start high", 0, 3, 30, 12, 1'b1, 0);
    measure("R7 code2 start high", 0, 2, 50, 20, 1'b1, 0);
    measure("R1 code0 start high", 0, 0, 40, 25, 1'b1, 0);
    timeout_run();
    measure("R4 after timeout", 0, 0, 36, 9, 1'b0, 0);
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog expired actual=hung expected=finished");
    report();
  end
endmodule